// File: doc/BRIEF.md
# Multiprocessor UART Address-Filtering Receiver

This block receives asynchronous serial frames from a line shared by one master and several slaves. Each frame has a low start bit, then 7 or 8 data bits, then one extra flag bit that tells address frames from data frames, then 1 or 2 high stop bits. There is no parity. The serial input is synchronised, and a falling edge restarts a counter. That counter advances on an external oversampling tick, and each bit is sampled in its middle.

A frame whose flag is 1 carries a slave address. Such a frame is always reported, and it also decides whether this receiver is selected: the receiver is selected when the address matches the programmed one and deselected when it does not. A frame whose flag is 0 carries data. It is reported only while the receiver is selected. A frame with a bad stop bit raises a framing-error strobe instead and is otherwise dropped.

Top module: `mp_addr_rx`

## Requirements
- R1: After reset, `out_valid`, `out_frame_err`, `out_is_addr` and `out_word` are 0, and the receiver is deselected, so a data frame sent before any address frame produces no `out_valid`.
- R2: A frame starts at a falling edge of the synchronised line. If the line is high again at the middle of the start bit, the edge is ignored and no strobe of either kind follows.
- R3: `cfg_bits8`=1 receives 8 data bits and `cfg_bits8`=0 receives 7. In 7-bit mode `out_word[7]` is 0.
- R4: `cfg_msb_first`=0 takes the first data bit on the line as bit 0 of the word. `cfg_msb_first`=1 takes the first data bit on the line as the top bit of the word (bit 7 or bit 6).
- R5: The flag bit follows the last data bit on the line, whatever the bit order. Flag 1 marks an address frame and flag 0 marks a data frame.
- R6: `cfg_stop2`=0 checks one stop bit and `cfg_stop2`=1 checks two. A low level at any stop-bit sample gives a one-cycle `out_frame_err` with no `out_valid`, and the frame changes neither the output word nor the selection.
- R7: Every error-free address frame gives a one-cycle `out_valid` with `out_is_addr`=1 and the address on `out_word`.
- R8: An address frame selects the receiver when it equals `cfg_slave_addr` (all 8 bits in 8-bit mode, bits 6:0 in 7-bit mode) and deselects it otherwise. A data frame that immediately follows it already sees the new selection.
- R9: An error-free data frame gives a one-cycle `out_valid` with `out_is_addr`=0 and the data on `out_word` only while the receiver is selected. Otherwise it gives no strobe.
- R10: `out_valid` and `out_frame_err` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, OVS ticks per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits8 | input | 1 | 1 for 8 data bits, 0 for 7 |
| cfg_stop2 | input | 1 | 1 for two stop bits, 0 for one |
| cfg_msb_first | input | 1 | 1 for MSB first, 0 for LSB first |
| cfg_slave_addr | input | 8 | Address of this slave |
| out_word | output | 8 | Received address or data |
| out_is_addr | output | 1 | Flag bit of the reported frame |
| out_valid | output | 1 | One-cycle strobe for a reported frame |
| out_frame_err | output | 1 | One-cycle strobe for a bad stop bit |

## Verification
An address frame updates the selection on the same clock edge that reports it, and the stop-bit check of that same frame decides whether the selection may change at all. The bench provokes both coincidences. It sends a data frame right after an address frame with no idle gap, and it sends address frames whose stop bit is forced low. It judges the results by whether the following data frames are delivered or suppressed, as its own selection model predicts.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_FLAG, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              flag;
    logic              ferr;
  } rx_frame_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic rxd_s,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rxd};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rxd_s = sh_q[STAGES-1];
  assign fall  = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import mpuart_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rxd_s,
  input  logic      fall,
  input  logic      bits8,
  input  logic      stop2,
  input  logic      msb_first,
  output logic      done,
  output rx_frame_t frame
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int IW = $clog2(WORD_W);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] word_q;
  logic              flag_q, ferr_q, done_q;
  logic [IW-1:0]     last_idx, pos;

  assign last_idx = bits8 ? IW'(WORD_W - 1) : IW'(WORD_W - 2);
  assign pos      = msb_first ? (last_idx - idx_q) : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      word_q <= '0;
      flag_q <= 1'b0;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (fall) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              if (rxd_s) begin
                st_q <= ST_IDLE;
              end else begin
                st_q   <= ST_DATA;
                idx_q  <= '0;
                word_q <= '0;
                ferr_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (cnt_q == FULL_M1) begin
              cnt_q <= '0;
              case (st_q)
                ST_DATA: begin
                  word_q[pos] <= rxd_s;
                  if (idx_q == last_idx) st_q <= ST_FLAG;
                  else idx_q <= idx_q + 1'b1;
                end
                ST_FLAG: begin
                  flag_q <= rxd_s;
                  st_q   <= ST_STOP1;
                end
                ST_STOP1: begin
                  ferr_q <= ~rxd_s;
                  if (stop2) begin
                    st_q <= ST_STOP2;
                  end else begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                  end
                end
                ST_STOP2: begin
                  ferr_q <= ferr_q | ~rxd_s;
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end
                default: st_q <= ST_IDLE;
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign done  = done_q;
  assign frame = '{word: word_q, flag: flag_q, ferr: ferr_q};
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import mpuart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_frame_t         frame,
  input  logic              bits8,
  input  logic [WORD_W-1:0] slave_addr,
  output logic [WORD_W-1:0] out_word,
  output logic              out_is_addr,
  output logic              out_valid,
  output logic              out_ferr,
  output logic              sel
);
  logic match;
  assign match = bits8 ? (frame.word == slave_addr)
                       : (frame.word[WORD_W-2:0] == slave_addr[WORD_W-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word    <= '0;
      out_is_addr <= 1'b0;
      out_valid   <= 1'b0;
      out_ferr    <= 1'b0;
      sel         <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_ferr  <= 1'b0;
      if (done) begin
        if (frame.ferr) begin
          out_ferr <= 1'b1;
        end else if (frame.flag) begin
          out_valid   <= 1'b1;
          out_is_addr <= 1'b1;
          out_word    <= frame.word;
          sel         <= match;
        end else if (sel) begin
          out_valid   <= 1'b1;
          out_is_addr <= 1'b0;
          out_word    <= frame.word;
        end
      end
    end
  end
endmodule

// File: rtl/mp_addr_rx.sv
module mp_addr_rx
  import mpuart_pkg::*;
#(
  parameter int OVS         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              cfg_bits8,
  input  logic              cfg_stop2,
  input  logic              cfg_msb_first,
  input  logic [WORD_W-1:0] cfg_slave_addr,
  output logic [WORD_W-1:0] out_word,
  output logic              out_is_addr,
  output logic              out_valid,
  output logic              out_frame_err
);
  logic      rxd_s, fall, done, sel_q;
  rx_frame_t frame;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .rxd(rxd), .rxd_s(rxd_s), .fall(fall)
  );

  rx_frame_fsm #(.OVS(OVS)) fsm_i (
    .clk(clk), .rst(rst), .tick(os_tick), .rxd_s(rxd_s), .fall(fall),
    .bits8(cfg_bits8), .stop2(cfg_stop2), .msb_first(cfg_msb_first),
    .done(done), .frame(frame)
  );

  rx_addr_filter filt_i (
    .clk(clk), .rst(rst), .done(done), .frame(frame), .bits8(cfg_bits8),
    .slave_addr(cfg_slave_addr), .out_word(out_word),
    .out_is_addr(out_is_addr), .out_valid(out_valid),
    .out_ferr(out_frame_err), .sel(sel_q)
  );
endmodule

// File: rtl/mp_addr_rx_chk.sv
module mp_addr_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_frame_err,
  input logic       out_is_addr,
  input logic       cfg_bits8,
  input logic [7:0] out_word,
  input logic       sel_q
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_frame_err));
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    out_frame_err |=> !out_frame_err);
  a_r9_data_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_addr) |-> sel_q);
  a_r3_seven_bit_top_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_bits8) |-> (out_word[7] == 1'b0));
  a_r6_err_keeps_sel: assert property (@(posedge clk) disable iff (rst)
    out_frame_err |-> (sel_q == $past(sel_q)));
endmodule

bind mp_addr_rx mp_addr_rx_chk chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_frame_err(out_frame_err),
  .out_is_addr(out_is_addr), .cfg_bits8(cfg_bits8), .out_word(out_word),
  .sel_q(sel_q)
);

// File: tb/mp_addr_rx_tb_top.sv
`timescale 1ns/1ps
module mp_addr_rx_tb_top;
  localparam int OVS = 8;
  localparam int DIV = 4;
  localparam int BT  = OVS * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_bits8 = 1'b1, cfg_stop2 = 1'b0, cfg_msb_first = 1'b0;
  logic [7:0] cfg_slave_addr = 8'h5A;
  logic [7:0] out_word;
  logic       out_is_addr, out_valid, out_frame_err;

  int n_tests = 0, n_fail = 0;
  int v_cnt = 0, e_cnt = 0;
  logic [7:0] v_word;
  logic       v_addr;
  bit   sel_m = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  mp_addr_rx #(.OVS(OVS)) dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .cfg_bits8(cfg_bits8), .cfg_stop2(cfg_stop2),
    .cfg_msb_first(cfg_msb_first), .cfg_slave_addr(cfg_slave_addr),
    .out_word(out_word), .out_is_addr(out_is_addr),
    .out_valid(out_valid), .out_frame_err(out_frame_err)
  );

  initial begin
    forever begin
      for (int i = 0; i < DIV; i++) begin
        @(negedge clk);
        os_tick = (i == DIV - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        v_cnt++;
        v_word = out_word;
        v_addr = out_is_addr;
      end
      if (out_frame_err) e_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] w, input logic flag, input bit bad_stop);
    int nb;
    nb = cfg_bits8 ? 8 : 7;
    v_cnt = 0;
    e_cnt = 0;
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++)
      hold_bit(cfg_msb_first ? w[nb-1-i] : w[i]);
    hold_bit(flag);
    if (cfg_stop2) begin
      hold_bit(1'b1);
      hold_bit(!bad_stop);
    end else begin
      hold_bit(!bad_stop);
    end
    rxd = 1'b1;
  endtask

  // Expected outcome from the requirements, followed by the check.
  task automatic frame_check(input logic [7:0] w_in, input logic flag,
                             input bit bad, input string req);
    logic [7:0] w;
    bit         match;
    w = cfg_bits8 ? w_in : {1'b0, w_in[6:0]};
    match = cfg_bits8 ? (w == cfg_slave_addr) : (w[6:0] == cfg_slave_addr[6:0]);
    send(w_in, flag, bad);
    if (bad) begin
      // R6: framing error, no strobe, selection untouched
      check(e_cnt == 1 && v_cnt == 0, "R6", "ferr/valid count",
            {e_cnt[15:0], v_cnt[15:0]}, 32'h0001_0000);
      hold_bit(1'b1);
    end else if (flag) begin
      check(v_cnt == 1 && e_cnt == 0 && v_addr == 1'b1 && v_word == w, req,
            "address report", {v_cnt[7:0], 7'd0, v_addr, v_word}, {8'd1, 8'd1, w});
      sel_m = match;
    end else if (sel_m) begin
      check(v_cnt == 1 && e_cnt == 0 && v_addr == 1'b0 && v_word == w, req,
            "data report", {v_cnt[7:0], 7'd0, v_addr, v_word}, {8'd1, 8'd0, w});
    end else begin
      check(v_cnt == 0 && e_cnt == 0, "R9", "deselected data strobes",
            {e_cnt[15:0], v_cnt[15:0]}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0 && out_frame_err == 0 && out_word == 0 && out_is_addr == 0,
          "R1", "reset outputs", {out_valid, out_frame_err, out_is_addr, out_word}, 0);
    // R1: deselected, data before any address is dropped
    frame_check(8'h33, 1'b0, 1'b0, "R1");
    // R2: short glitch ignored
    v_cnt = 0; e_cnt = 0;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    check(v_cnt == 0 && e_cnt == 0, "R2", "glitch strobes", {e_cnt[15:0], v_cnt[15:0]}, 0);
    // R7 R8: matching address, then R5 R9 back-to-back data
    frame_check(8'h5A, 1'b1, 1'b0, "R8");
    frame_check(8'hC3, 1'b0, 1'b0, "R5");
    // R4: MSB first data
    cfg_msb_first = 1'b1;
    frame_check(8'h81, 1'b0, 1'b0, "R4");
    frame_check(8'h12, 1'b0, 1'b0, "R4");
    cfg_msb_first = 1'b0;
    // R6: bad stop on a non-matching address keeps selection
    frame_check(8'h11, 1'b1, 1'b1, "R6");
    frame_check(8'h77, 1'b0, 1'b0, "R6");
    // R8: mismatch deselects, R7 still reported
    frame_check(8'h11, 1'b1, 1'b0, "R7");
    frame_check(8'h77, 1'b0, 1'b0, "R9");
    // R6 with two stop bits, second one low
    cfg_stop2 = 1'b1;
    frame_check(8'h5A, 1'b1, 1'b1, "R6");
    frame_check(8'h66, 1'b0, 1'b0, "R6");
    frame_check(8'h5A, 1'b1, 1'b0, "R8");
    frame_check(8'hFE, 1'b0, 1'b0, "R9");
    // R3: seven-bit mode, top bit of address ignored in the match
    cfg_bits8 = 1'b0;
    frame_check(8'hDA, 1'b1, 1'b0, "R3");
    frame_check(8'hFF, 1'b0, 1'b0, "R3");
    cfg_msb_first = 1'b1;
    frame_check(8'h41, 1'b0, 1'b0, "R3");
    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] w;
      logic       fl;
      bit         bad;
      cfg_bits8     = $urandom_range(0, 1);
      cfg_stop2     = $urandom_range(0, 1);
      cfg_msb_first = $urandom_range(0, 1);
      fl  = ($urandom_range(0, 3) == 0);
      bad = ($urandom_range(0, 7) == 0);
      w   = fl && $urandom_range(0, 1) ? cfg_slave_addr : 8'($urandom);
      frame_check(w, fl, bad, fl ? "R8" : "R9");
      repeat ($urandom_range(0, 2) * BT) @(negedge clk);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule